// File: doc/BRIEF.md
# Address-Windowed Memory Response Generator

This block answers read and write requests arriving on a request stream and returns response beats on a response stream. One address window is backed by real storage. Every word address whose bits above a 16-bit offset equal the window tag 0x12 maps to a local RAM of 1024 words of 64 bits. Writes there are kept and can be read back at any later time. Any other address needs no storage: a read returns a repeatable pattern derived from the beat's own address, and a write there is acknowledged and dropped.

A request is one beat for a read. A write has one beat per data word. The first beat carries the type, transaction ID, starting word address and length; write beats also carry their data. A burst covers `req_len + 1` words at incrementing word addresses, and each beat is decoded against the window on its own. A read produces one data response beat per word, at one beat per cycle while `rsp_ready` is high. A write produces a single completion beat once all of its data beats have been taken. The block serves one request at a time.

Top module: `mem_resp_gen`

## Requirements
- R1: After a synchronous active-high reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A word address lies in the window when bits [31:16] equal 16'h0012. Inside the window, bits [9:0] select the RAM word, so offsets 0x0400 apart share one location.
- R3: A read of a window address returns the data most recently written to that RAM word, however many requests came in between.
- R4: A read beat at a word address A outside the window returns `{32'h0, A} ^ 64'hA5C3_0F96_5A3C_F069`. A write beat outside the window changes no stored word and no later response.
- R5: A write gets exactly one response beat, after its last data beat is accepted. That beat has `rsp_status` = 2'b10 (done), `rsp_last` = 1, `rsp_data` = 0 and the request's ID.
- R6: A read of length field L gets L+1 response beats with `rsp_status` = 2'b01 (data) and the request's ID. Beat i carries the data for word address start+i, and `rsp_last` is 1 only on beat L.
- R7: `req_ready` is 0 whenever a response is being offered. It is 1 when idle and while write data beats are being taken.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold their values into the next cycle.
- R9: While `rsp_ready` stays 1, the beats of a read come out on consecutive cycles with no gap.
- R10: A burst that crosses a window edge decides window or pattern for each beat separately, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Request beat accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read (sampled on the first beat) |
| req_id | input | ID_W (8) | Transaction ID (sampled on the first beat) |
| req_addr | input | ADDR_W (32) | Starting word address (sampled on the first beat) |
| req_len | input | LEN_W (4) | Words in the burst minus one (sampled on the first beat) |
| req_data | input | DATA_W (64) | Write data for this beat |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response beat taken when high together with rsp_valid |
| rsp_id | output | ID_W (8) | Echoed transaction ID |
| rsp_status | output | 2 | 2'b01 read data, 2'b10 write done |
| rsp_last | output | 1 | Final beat of the response |
| rsp_data | output | DATA_W (64) | Read data, or zero on a write completion |

## Verification
Corrupt RAM contents or a wrong window decode appears at the ports only when a later read reaches the affected word. The bench therefore fills the whole window first, keeps a full shadow of the RAM, and compares every read beat against it, so a stale or misplaced word shows in the first beat that touches it. A wrong beat counter or address counter shows within the same burst as a misplaced `rsp_last`, a wrong beat count or a shifted data word. Stalled-output faults show in the very next cycle of a `rsp_ready` stall.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_WRSP = 2'd2,
    ST_RD   = 2'd3
  } mrg_state_e;

  localparam logic [1:0] RSP_DATA = 2'b01;
  localparam logic [1:0] RSP_DONE = 2'b10;
endpackage

// File: rtl/mrg_addr_map.sv
// Window decode and synthetic read pattern for one word address.
// DATA_W must be larger than ADDR_W.
module mrg_addr_map #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-OFF_W-1:0] WIN_TAG = 16'h0012,
  parameter logic [DATA_W-1:0] PAT_KEY = 64'hA5C3_0F96_5A3C_F069
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [DATA_W-1:0] pattern
);
  assign in_win  = (addr[ADDR_W-1:OFF_W] == WIN_TAG);
  assign pattern = {{(DATA_W-ADDR_W){1'b0}}, addr} ^ PAT_KEY;
endmodule

// File: rtl/mrg_window_ram.sv
// Simple dual-port RAM with a registered read port, so block RAM can be inferred.
module mrg_window_ram #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mem_resp_gen.sv
module mem_resp_gen #(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 1024,
  parameter logic [ADDR_W-OFF_W-1:0] WIN_TAG = 16'h0012,
  parameter logic [DATA_W-1:0] PAT_KEY = 64'hA5C3_0F96_5A3C_F069
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic [1:0]        rsp_status,
  output logic              rsp_last,
  output logic [DATA_W-1:0] rsp_data
);
  import mrg_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);

  mrg_state_e        state;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cnt;

  logic [ADDR_W-1:0] beat_addr;
  logic [ADDR_W-1:0] next_addr;
  logic              in_win;
  logic [DATA_W-1:0] pattern;
  logic              req_fire;
  logic              rsp_fire;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_raddr;
  logic [DATA_W-1:0] ram_q;

  // Address of the beat being handled this cycle
  assign beat_addr = (state == ST_IDLE) ? req_addr : cur_addr;
  assign next_addr = cur_addr + 1'b1;

  assign req_ready = (state == ST_IDLE) || (state == ST_WR);
  assign rsp_valid = (state == ST_RD) || (state == ST_WRSP);
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;

  assign ram_we    = req_fire && in_win && ((state == ST_WR) || req_write);
  // Read port runs one word ahead on an accepted beat so data is ready next cycle
  assign ram_raddr = (state == ST_RD && rsp_fire) ? next_addr[IDX_W-1:0]
                                                  : beat_addr[IDX_W-1:0];

  mrg_addr_map #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W),
    .WIN_TAG(WIN_TAG),
    .PAT_KEY(PAT_KEY)
  ) u_map (
    .addr   (beat_addr),
    .in_win (in_win),
    .pattern(pattern)
  );

  mrg_window_ram #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(beat_addr[IDX_W-1:0]),
    .wdata(req_data),
    .raddr(ram_raddr),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      id_q     <= '0;
      cur_addr <= '0;
      cnt      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_fire) begin
            id_q <= req_id;
            if (req_write) begin
              cur_addr <= req_addr + 1'b1;
              cnt      <= req_len - 1'b1;
              state    <= (req_len == '0) ? ST_WRSP : ST_WR;
            end else begin
              cur_addr <= req_addr;
              cnt      <= req_len;
              state    <= ST_RD;
            end
          end
        end
        ST_WR: begin
          if (req_fire) begin
            cur_addr <= next_addr;
            cnt      <= cnt - 1'b1;
            if (cnt == '0) state <= ST_WRSP;
          end
        end
        ST_WRSP: begin
          if (rsp_fire) state <= ST_IDLE;
        end
        ST_RD: begin
          if (rsp_fire) begin
            cur_addr <= next_addr;
            cnt      <= cnt - 1'b1;
            if (cnt == '0) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_id     = id_q;
  assign rsp_status = (state == ST_RD) ? RSP_DATA : RSP_DONE;
  assign rsp_last   = (state == ST_WRSP) || ((state == ST_RD) && (cnt == '0));
  assign rsp_data   = (state != ST_RD) ? '0 : (in_win ? ram_q : pattern);
endmodule

// File: rtl/mem_resp_gen_chk.sv
module mem_resp_gen_chk #(
  parameter int ID_W   = 8,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ID_W-1:0]   rsp_id,
  input logic [1:0]        rsp_status,
  input logic              rsp_last,
  input logic [DATA_W-1:0] rsp_data
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && req_ready));

  assert_done_shape_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'b10) |-> (rsp_last && rsp_data == '0));

  assert_status_legal_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status == 2'b01 || rsp_status == 2'b10));

  assert_burst_id_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready && !rsp_last) |=> $stable(rsp_id));

  assert_no_accept_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_id)
                                   && $stable(rsp_status) && $stable(rsp_last)));

  assert_gapless_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready && !rsp_last) |=> rsp_valid);
endmodule

bind mem_resp_gen mem_resp_gen_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_id    (rsp_id),
  .rsp_status(rsp_status),
  .rsp_last  (rsp_last),
  .rsp_data  (rsp_data)
);

// File: tb/mem_resp_gen_tb.sv
`timescale 1ns/1ps
module mem_resp_gen_tb;
  localparam logic [63:0] KEY = 64'hA5C3_0F96_5A3C_F069;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_id = '0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [63:0] req_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_id;
  logic [1:0]  rsp_status;
  logic        rsp_last;
  logic [63:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [63:0] model [1024];

  always #4 clk = ~clk;

  mem_resp_gen u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_id(req_id), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
    .rsp_status(rsp_status), .rsp_last(rsp_last), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit in_window(input logic [31:0] a);
    return a[31:16] == 16'h0012;
  endfunction

  function automatic logic [63:0] exp_beat(input logic [31:0] a);
    if (in_window(a)) return model[a[9:0]];
    return {32'h0, a} ^ KEY;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive a request; writes send len+1 data beats and update the shadow model
  task automatic issue(input bit wr, input logic [7:0] id, input logic [31:0] addr,
                       input logic [3:0] len);
    int beats = wr ? int'(len) + 1 : 1;
    for (int b = 0; b < beats; b++) begin
      logic [63:0] d;
      logic [31:0] a;
      @(negedge clk);
      d = {$urandom, $urandom};
      a = addr + b;
      req_valid = 1'b1; req_write = wr; req_id = id; req_addr = addr;
      req_len = len; req_data = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      if (wr && in_window(a)) model[a[9:0]] = d;   // R10: per-beat decode
    end
    #1 req_valid = 1'b0;
  endtask

  // Collect and check all response beats of one request
  task automatic collect(input bit wr, input logic [7:0] id, input logic [31:0] addr,
                         input logic [3:0] len, input bit allready);
    int nb = wr ? 1 : int'(len) + 1;
    int i = 0;
    int cyc = 0;
    int first = -1;
    int lastc = 0;
    bit stalled = 0;
    bit r7done = 0;
    logic [63:0] prev_d = '0;
    while (i < nb) begin
      @(negedge clk);
      rsp_ready = allready ? 1'b1 : (($urandom % 10) < 7);
      if (stalled)
        check(rsp_valid && rsp_data == prev_d, "R8", "held data under stall", rsp_data, prev_d);
      if (rsp_valid) begin
        if (first < 0) first = cyc;
        if (!r7done) begin
          check(req_ready == 1'b0, "R7", "req_ready during response", 64'(req_ready), 64'd0);
          r7done = 1;
        end
        if (rsp_ready) begin
          check(rsp_id == id, "R6", "response id", 64'(rsp_id), 64'(id));
          if (wr) begin
            check(rsp_status == 2'b10 && rsp_last && rsp_data == 64'd0, "R5",
                  "write done beat {status,last,data}", {rsp_status, rsp_last, rsp_data[60:0]},
                  {2'b10, 1'b1, 61'd0});
          end else begin
            logic [31:0] a = addr + i;
            check(rsp_status == 2'b01, "R6", "read status", 64'(rsp_status), 64'd1);
            check(rsp_last == (i == nb - 1), "R6", "read last flag", 64'(rsp_last), 64'(i == nb - 1));
            if (in_window(a))
              check(rsp_data == exp_beat(a), "R3", "window read data", rsp_data, exp_beat(a));
            else
              check(rsp_data == exp_beat(a), "R4", "pattern read data", rsp_data, exp_beat(a));
          end
          lastc = cyc;
          i++;
          stalled = 0;
        end else begin
          stalled = 1;
          prev_d = rsp_data;
        end
      end
      cyc++;
    end
    if (allready && !wr)
      check(lastc - first == nb - 1, "R9", "cycles from first to last beat",
            64'(lastc - first), 64'(nb - 1));
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  task automatic xfer(input bit wr, input logic [7:0] id, input logic [31:0] addr,
                      input logic [3:0] len, input bit allready);
    issue(wr, id, addr, len);
    collect(wr, id, addr, len, allready);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    for (int k = 0; k < 1024; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1", "reset state {valid,ready}",
          {62'd0, rsp_valid, req_ready}, 64'd1);

    // Fill the whole window so every location is known (R2, R5)
    for (int base = 0; base < 1024; base += 16)
      xfer(1'b1, 8'(base >> 4), 32'h0012_0000 + base, 4'd15, 1'b1);

    // R2: offset 0x0400 aliases offset 0
    xfer(1'b1, 8'h21, 32'h0012_0400, 4'd0, 1'b1);
    xfer(1'b0, 8'h22, 32'h0012_0000, 4'd0, 1'b1);
    // R4: write outside the window is dropped; readback still gives the pattern
    xfer(1'b1, 8'h31, 32'h0013_0005, 4'd2, 1'b0);
    xfer(1'b0, 8'h32, 32'h0013_0005, 4'd2, 1'b0);
    // R4: window RAM at the same low index is unchanged
    xfer(1'b0, 8'h33, 32'h0012_0005, 4'd2, 1'b1);
    // R10: bursts crossing the window edges both ways
    xfer(1'b1, 8'h41, 32'h0012_FFFE, 4'd3, 1'b1);
    xfer(1'b0, 8'h42, 32'h0012_FFFC, 4'd7, 1'b1);
    xfer(1'b1, 8'h43, 32'h0011_FFFE, 4'd3, 1'b0);
    xfer(1'b0, 8'h44, 32'h0011_FFFC, 4'd7, 1'b0);
    // R9: longest read with rsp_ready held high
    xfer(1'b0, 8'h51, 32'h0012_0100, 4'd15, 1'b1);
    xfer(1'b0, 8'h52, 32'h7777_0000, 4'd15, 1'b1);
    // R3: data survives unrelated traffic
    xfer(1'b1, 8'h61, 32'h0012_0200, 4'd1, 1'b1);
    xfer(1'b0, 8'h62, 32'h0055_0200, 4'd3, 1'b1);
    xfer(1'b0, 8'h63, 32'h0012_0200, 4'd1, 1'b0);

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      int mode = $urandom % 4;
      case (mode)
        0: a = 32'h0012_0000 | ($urandom & 32'hFFFF);
        1: a = $urandom;
        2: a = 32'h0012_FFF0 + ($urandom % 16);
        default: a = 32'h0011_FFF0 + ($urandom % 16);
      endcase
      xfer(($urandom % 2) == 1, 8'($urandom), a, 4'($urandom), ($urandom % 3) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule